// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates among a parameterized set of interrupt request lines and one non-maskable request for a small processor core. Software programs it through a simple word-addressed register bus: each line has an enable bit, a pending bit, a trigger-mode bit (held level or single pulse) and a 4-bit priority. An active bit is kept per line while its handler runs. Enable and pending are each reached through a pair of views, one that sets bits and one that clears bits. A write-only trigger register makes any line pending by number.

Every cycle the controller picks the most urgent pending and enabled line and offers it to the core with a request flag and a line number. Priorities split into a group part and a subpriority part at a programmable point. The group part alone decides whether an offer may preempt the running handler. The full priority, then the lowest line number, orders the candidates. The core answers with an acknowledge strobe when it enters a handler and an end strobe when it leaves one. If an end strobe finds a candidate that is eligible against the handlers still running, the controller hands that candidate over in the same step and flags a chained dispatch. The request does not drop back to idle in between.

Top module: `pvic_top`

## Requirements
- R1: After reset, every enable, pending, active, mode, priority and split bit reads 0. No request and no chained dispatch is signalled.
- R2: The enable state is written with one bits at word offset 0x00, which sets bits, or at 0x04, which clears bits. Zero bits leave a line unchanged, and both offsets read the current enable state.
- R3: The pending state uses the same scheme, setting at 0x08 and clearing at 0x0C. If a hardware or software set and a clear hit the same line in the same cycle, the line stays pending.
- R4: Bit k of the mode register (0x14) selects how line k is detected. With 0 (level), the line is made pending in every cycle its input is high. With 1 (pulse), only a 0-to-1 transition sets pending, and the bit stays set after the input falls.
- R5: Writing a number k below the line count to the trigger register (0x1C) makes line k pending. A number at or above the line count changes nothing, and the register reads 0.
- R6: Among lines that are both pending and enabled, the one offered has the numerically smallest priority, with the lowest line number breaking ties. While `irq_req` is high and `irq_nmi` is low, `irq_id` names that line.
- R7: The priority of line k is the 4-bit field at bit 4*(k mod 8) of the word at offset 0x20 + 4*(k div 8), where 0 is most urgent. A rewritten priority steers the offer in the cycle after the write.
- R8: The low two bits of the split register (0x18) give the number of subpriority bits s. The group is the priority shifted right by s. While a handler is active, a line is offered only if its group is strictly smaller than that of the running handler.
- R9: An acknowledge while a maskable line is offered sets that line's active bit, read at 0x10, and clears its pending bit. An acknowledge with no offer changes nothing.
- R10: An end strobe clears the active bit of the running handler, which is the active line with the smallest group. If a pending, enabled line is eligible against the lines still active, it becomes active and not pending in the same step. The chained-dispatch flag then pulses for one cycle with that line's number.
- R11: A rising edge on `nmi_in` makes the non-maskable request pending. It is offered with `irq_nmi` high ahead of every maskable line, regardless of enables. After it is acknowledged nothing is offered until an end strobe closes it, and that end strobe may chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_in | input | NUM_IRQ | Interrupt request lines |
| nmi_in | input | 1 | Non-maskable request line |
| core_ack | input | 1 | Core has entered the offered handler |
| core_done | input | 1 | Core has left the running handler |
| irq_req | output | 1 | An interrupt is offered to the core |
| irq_nmi | output | 1 | The offer is the non-maskable request |
| irq_id | output | ID_W | Line number of the offered interrupt |
| chain_valid | output | 1 | One-cycle pulse: a chained dispatch took place |
| chain_nmi | output | 1 | The chained handler is the non-maskable one |
| chain_id | output | ID_W | Line number of the chained handler |

## Verification
Two things can collide in one cycle: a clear of the pending state and a new set of the same line. The bench provokes this by writing the clear view in the very cycle in which a pulse-mode input rises. It also clears a level-mode line while the input is still held. In both cases it reads the pending view back and expects the bit to survive. A second collision is the end of one handler with a pending, eligible line waiting. The bench judges this by the chained-dispatch pulse and the line number it carries, and by the active and pending views read right after. It covers chaining from a maskable handler, from the non-maskable one, and into the non-maskable one.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    localparam int PRIO_W   = 4;
    localparam int SPLIT_W  = 2;
    localparam int NUM_W    = 5;
    localparam int SLOTS    = 8;

    localparam int OFF_ENA_SET = 'h00;
    localparam int OFF_ENA_CLR = 'h04;
    localparam int OFF_PND_SET = 'h08;
    localparam int OFF_PND_CLR = 'h0C;
    localparam int OFF_ACTIVE  = 'h10;
    localparam int OFF_MODE    = 'h14;
    localparam int OFF_SPLIT   = 'h18;
    localparam int OFF_SWTRIG  = 'h1C;
    localparam int OFF_PRIO    = 'h20;

    typedef logic [PRIO_W-1:0]  prio_t;
    typedef logic [SPLIT_W-1:0] split_t;
    typedef logic [NUM_W-1:0]   num_t;

    typedef struct packed {
        logic  valid;
        num_t  num;
        prio_t grp;
    } pick_t;

    function automatic prio_t grp_of(prio_t p, split_t s);
        return p >> s;
    endfunction

    function automatic logic [31:0] hot_of(num_t n);
        return 32'(1) << n;
    endfunction

endpackage

// File: rtl/pvic_regs.sv
module pvic_regs
    import pvic_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_IRQ-1:0] enable_o,
    output logic [NUM_IRQ-1:0] mode_o,
    output prio_t              prio_o [NUM_IRQ],
    output split_t             split_o,
    output logic [NUM_IRQ-1:0] pset_o,
    output logic [NUM_IRQ-1:0] pclr_o,
    output logic               sw_valid_o,
    output num_t               sw_num_o
);
    localparam int WA = ADDR_W - 2;

    logic [WA-1:0]      wa;
    logic               wr_ok;
    logic               hit_es, hit_ec, hit_ps, hit_pc, hit_mode, hit_split, hit_sw;
    logic [NUM_IRQ-1:0] wbits;
    logic [NUM_IRQ-1:0] enable_q, mode_q;
    prio_t              prio_q [NUM_IRQ];
    split_t             split_q;

    assign wa    = addr[ADDR_W-1:2];
    assign wr_ok = we && (addr[1:0] == 2'b00);
    assign wbits = wdata[NUM_IRQ-1:0];

    always_comb begin
        hit_es    = wr_ok && (wa == WA'(OFF_ENA_SET / 4));
        hit_ec    = wr_ok && (wa == WA'(OFF_ENA_CLR / 4));
        hit_ps    = wr_ok && (wa == WA'(OFF_PND_SET / 4));
        hit_pc    = wr_ok && (wa == WA'(OFF_PND_CLR / 4));
        hit_mode  = wr_ok && (wa == WA'(OFF_MODE / 4));
        hit_split = wr_ok && (wa == WA'(OFF_SPLIT / 4));
        hit_sw    = wr_ok && (wa == WA'(OFF_SWTRIG / 4));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            mode_q   <= '0;
            split_q  <= '0;
        end else begin
            if (hit_es)
                enable_q <= enable_q | wbits;
            else if (hit_ec)
                enable_q <= enable_q & ~wbits;
            if (hit_mode)
                mode_q <= wbits;
            if (hit_split)
                split_q <= wdata[SPLIT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_IRQ; k++)
                prio_q[k] <= '0;
        end else begin
            for (int k = 0; k < NUM_IRQ; k++)
                if (wr_ok && (wa == WA'(OFF_PRIO / 4 + k / SLOTS)))
                    prio_q[k] <= wdata[PRIO_W*(k%SLOTS) +: PRIO_W];
        end
    end

    assign enable_o   = enable_q;
    assign mode_o     = mode_q;
    assign prio_o     = prio_q;
    assign split_o    = split_q;
    assign pset_o     = hit_ps ? wbits : '0;
    assign pclr_o     = hit_pc ? wbits : '0;
    assign sw_valid_o = hit_sw && (wdata < DATA_W'(NUM_IRQ));
    assign sw_num_o   = wdata[NUM_W-1:0];

    assert_ena_clear_R2: assert property (@(posedge clk) disable iff (rst)
        hit_ec |=> ((enable_q & $past(wbits)) == '0));

    assert_zero_write_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        ((hit_es || hit_ec) && (wbits == '0)) |=> $stable(enable_q));

endmodule

// File: rtl/pvic_pend.sv
module pvic_pend
    import pvic_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] mode,
    input  logic [NUM_IRQ-1:0] set_w,
    input  logic [NUM_IRQ-1:0] clr_w,
    input  logic               sw_valid,
    input  num_t               sw_num,
    input  logic [NUM_IRQ-1:0] take_clr,
    input  logic               nmi_in,
    input  logic               nmi_clr,
    output logic [NUM_IRQ-1:0] pend_o,
    output logic               nmi_pend_o
);
    logic [NUM_IRQ-1:0] hw_set, sw_hot, sets, clears, pend_q;
    logic               nmi_prev_q, nmi_pend_q;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= irq_in[i];
        end
        assign hw_set[i] = mode[i] ? (irq_in[i] & ~prev_q) : irq_in[i];
        assign sw_hot[i] = sw_valid && (sw_num == NUM_W'(i));

        assert_pend_holds_R3: assert property (@(posedge clk) disable iff (rst)
            (pend_q[i] && !clears[i]) |=> pend_q[i]);
        assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
            sets[i] |=> pend_q[i]);
    end

    assign sets   = hw_set | set_w | sw_hot;
    assign clears = clr_w | take_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= '0;
            nmi_prev_q <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            pend_q     <= (pend_q & ~clears) | sets;
            nmi_prev_q <= nmi_in;
            nmi_pend_q <= (nmi_pend_q & ~nmi_clr) | (nmi_in & ~nmi_prev_q);
        end
    end

    assign pend_o     = pend_q;
    assign nmi_pend_o = nmi_pend_q;

    assert_nmi_latch_R11: assert property (@(posedge clk) disable iff (rst)
        (nmi_pend_q && !nmi_clr) |=> nmi_pend_q);

endmodule

// File: rtl/pvic_arb.sv
module pvic_arb
    import pvic_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] cand,
    input  prio_t              prio [NUM_IRQ],
    input  split_t             split,
    output pick_t              best_o
);
    localparam int ID_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic  bv;
    num_t  bn;
    prio_t bp;

    always_comb begin
        bv = 1'b0;
        bn = '0;
        bp = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand[i] && (!bv || (prio[i] < bp))) begin
                bv = 1'b1;
                bn = NUM_W'(i);
                bp = prio[i];
            end
        end
    end

    assign best_o = '{valid: bv, num: bn, grp: grp_of(bp, split)};

    assert_best_is_cand_R6: assert property (@(posedge clk) disable iff (rst)
        bv |-> cand[bn[ID_W-1:0]]);

endmodule

// File: rtl/pvic_actmin.sv
module pvic_actmin
    import pvic_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] act,
    input  prio_t              prio [NUM_IRQ],
    input  split_t             split,
    output pick_t              run_o
);
    localparam int ID_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    pick_t r;

    always_comb begin
        r = '{valid: 1'b0, num: '0, grp: '1};
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (act[i] && (!r.valid || (grp_of(prio[i], split) < r.grp))) begin
                r.valid = 1'b1;
                r.num   = NUM_W'(i);
                r.grp   = grp_of(prio[i], split);
            end
        end
    end

    assign run_o = r;

    assert_run_is_active_R10: assert property (@(posedge clk) disable iff (rst)
        r.valid |-> act[r.num[ID_W-1:0]]);

endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    localparam int ID_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               nmi_in,
    input  logic               core_ack,
    input  logic               core_done,
    output logic               irq_req,
    output logic               irq_nmi,
    output logic [ID_W-1:0]    irq_id,
    output logic               chain_valid,
    output logic               chain_nmi,
    output logic [ID_W-1:0]    chain_id
);
    localparam int WA = ADDR_W - 2;

    logic [NUM_IRQ-1:0] enable, mode, pset, pclr, pending;
    prio_t              prio [NUM_IRQ];
    split_t             split;
    logic               sw_valid;
    num_t               sw_num;
    logic               nmi_pend;

    logic [NUM_IRQ-1:0] active_q;
    logic               nmi_act_q;
    logic               chain_v_q, chain_n_q;
    logic [ID_W-1:0]    chain_id_q;

    pick_t              best, run_now, run_after;
    logic [NUM_IRQ-1:0] pop_mask, act_after, best_hot, take_clr;
    logic               nmi_after, pop_valid;
    logic               nmi_go, msk_go, take, ack_nmi, ack_msk, c_nmi, c_msk;

    pvic_regs #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .enable_o(enable), .mode_o(mode), .prio_o(prio), .split_o(split),
        .pset_o(pset), .pclr_o(pclr), .sw_valid_o(sw_valid), .sw_num_o(sw_num)
    );

    pvic_pend #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk(clk), .rst(rst), .irq_in(irq_in), .mode(mode),
        .set_w(pset), .clr_w(pclr), .sw_valid(sw_valid), .sw_num(sw_num),
        .take_clr(take_clr), .nmi_in(nmi_in), .nmi_clr(c_nmi | ack_nmi),
        .pend_o(pending), .nmi_pend_o(nmi_pend)
    );

    pvic_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
        .clk(clk), .rst(rst), .cand(pending & enable), .prio(prio),
        .split(split), .best_o(best)
    );

    pvic_actmin #(.NUM_IRQ(NUM_IRQ)) u_run_now (
        .clk(clk), .rst(rst), .act(active_q), .prio(prio),
        .split(split), .run_o(run_now)
    );

    pvic_actmin #(.NUM_IRQ(NUM_IRQ)) u_run_after (
        .clk(clk), .rst(rst), .act(act_after), .prio(prio),
        .split(split), .run_o(run_after)
    );

    // Offer to the core, from the current state.
    assign nmi_go = nmi_pend && !nmi_act_q;
    assign msk_go = best.valid && !nmi_act_q &&
                    (!run_now.valid || (best.grp < run_now.grp));

    assign irq_req = nmi_go || msk_go;
    assign irq_nmi = nmi_go;
    assign irq_id  = nmi_go ? '0 : best.num[ID_W-1:0];

    // End of handler: the non-maskable one closes first, else the running line.
    assign pop_valid = core_done && (nmi_act_q || run_now.valid);
    assign pop_mask  = (core_done && !nmi_act_q && run_now.valid)
                       ? hot_of(run_now.num)[NUM_IRQ-1:0] : '0;
    assign act_after = active_q & ~pop_mask;
    assign nmi_after = nmi_act_q && !core_done;

    assign c_nmi = pop_valid && nmi_pend && !nmi_after;
    assign c_msk = pop_valid && !c_nmi && best.valid && !nmi_after &&
                   (!run_after.valid || (best.grp < run_after.grp));

    assign take    = core_ack && !core_done && irq_req;
    assign ack_nmi = take && irq_nmi;
    assign ack_msk = take && !irq_nmi;

    assign best_hot = hot_of(best.num)[NUM_IRQ-1:0];
    assign take_clr = (c_msk || ack_msk) ? best_hot : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= '0;
            nmi_act_q  <= 1'b0;
            chain_v_q  <= 1'b0;
            chain_n_q  <= 1'b0;
            chain_id_q <= '0;
        end else begin
            active_q   <= act_after | take_clr;
            nmi_act_q  <= nmi_after || c_nmi || ack_nmi;
            chain_v_q  <= c_nmi || c_msk;
            chain_n_q  <= c_nmi;
            chain_id_q <= c_nmi ? '0 : best.num[ID_W-1:0];
        end
    end

    assign chain_valid = chain_v_q;
    assign chain_nmi   = chain_n_q;
    assign chain_id    = chain_id_q;

    // Register read path.
    logic [WA-1:0] ra;
    assign ra = bus_addr[ADDR_W-1:2];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[1:0] == 2'b00) begin
            if (ra == WA'(OFF_ENA_SET / 4) || ra == WA'(OFF_ENA_CLR / 4))
                bus_rdata = DATA_W'(enable);
            else if (ra == WA'(OFF_PND_SET / 4) || ra == WA'(OFF_PND_CLR / 4))
                bus_rdata = DATA_W'(pending);
            else if (ra == WA'(OFF_ACTIVE / 4))
                bus_rdata = DATA_W'(active_q);
            else if (ra == WA'(OFF_MODE / 4))
                bus_rdata = DATA_W'(mode);
            else if (ra == WA'(OFF_SPLIT / 4))
                bus_rdata = DATA_W'(split);
            for (int k = 0; k < NUM_IRQ; k++)
                if (ra == WA'(OFF_PRIO / 4 + k / SLOTS))
                    bus_rdata[PRIO_W*(k%SLOTS) +: PRIO_W] = prio[k];
        end
    end

    assert_offer_is_cand_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_nmi) |-> (pending[irq_id] && enable[irq_id]));

    assert_ack_marks_active_R9: assert property (@(posedge clk) disable iff (rst)
        (core_ack && !core_done && irq_req && !irq_nmi) |=> active_q[$past(irq_id)]);

    assert_nmi_ack_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (core_ack && !core_done && irq_nmi) |=> nmi_act_q);

    assert_nmi_busy_silent_R11: assert property (@(posedge clk) disable iff (rst)
        nmi_act_q |-> !irq_req);

    assert_chain_is_active_R10: assert property (@(posedge clk) disable iff (rst)
        (chain_valid && !chain_nmi) |-> active_q[chain_id]);

    assert_pop_leaves_other_R10: assert property (@(posedge clk) disable iff (rst)
        (pop_valid && !nmi_act_q && run_after.valid) |-> (run_after.num != run_now.num));

endmodule

// File: tb/sim_pvic_top.sv
module sim_pvic_top;
    localparam int N  = 8;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int IW = 3;

    localparam logic [7:0] A_ES = 8'h00, A_EC = 8'h04, A_PS = 8'h08, A_PC = 8'h0C;
    localparam logic [7:0] A_ACT = 8'h10, A_MODE = 8'h14, A_SPLIT = 8'h18;
    localparam logic [7:0] A_SW = 8'h1C, A_PRIO0 = 8'h20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  irq_in = '0;
    logic nmi_in = 1'b0, core_ack = 1'b0, core_done = 1'b0;
    logic irq_req, irq_nmi, chain_valid, chain_nmi;
    logic [IW-1:0] irq_id, chain_id;

    always #5 clk = ~clk;

    pvic_top #(.NUM_IRQ(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .nmi_in(nmi_in), .core_ack(core_ack), .core_done(core_done),
        .irq_req(irq_req), .irq_nmi(irq_nmi), .irq_id(irq_id),
        .chain_valid(chain_valid), .chain_nmi(chain_nmi), .chain_id(chain_id)
    );

    // Scoreboard: kind 0 = read data, 1 = offer {req,nmi,id}, 2 = chain {valid,nmi,id}
    typedef struct {
        int          rq;
        int          kind;
        logic [31:0] exp;
    } item_t;

    item_t sb[$];
    item_t it;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    function automatic logic [31:0] observe(int kind);
        if (kind == 0) return bus_rdata;
        if (kind == 1) return {25'b0, irq_req, irq_nmi, 5'(irq_id)};
        return {25'b0, chain_valid, chain_nmi, 5'(chain_id)};
    endfunction

    always begin
        wait (sb.size() != 0);
        it = sb.pop_front();
        begin
            logic [31:0] got;
            bit ok;
            got = observe(it.kind);
            if (it.kind != 0 && it.exp[6] == 1'b0) ok = (got[6] == 1'b0);
            else ok = (got == it.exp);
            total++;
            if (!ok) begin
                bad++;
                $display("FAIL R%0d kind=%0d got=%h expected=%h", it.rq, it.kind, got, it.exp);
            end
        end
    end

    task automatic expect_it(int kind, logic [31:0] v, int rq);
        sb.push_back('{rq: rq, kind: kind, exp: v});
        #1;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, int rq);
        bus_addr = a;
        #1;
        expect_it(0, e, rq);
        tick();
    endtask

    task automatic offer(bit req, bit nmi, int id, int rq);
        #1;
        expect_it(1, {25'b0, req, nmi, 5'(id)}, rq);
    endtask

    task automatic chain(bit v, bit nmi, int id, int rq);
        #1;
        expect_it(2, {25'b0, v, nmi, 5'(id)}, rq);
    endtask

    task automatic ack();
        core_ack = 1'b1; tick(); core_ack = 1'b0;
    endtask

    task automatic done();
        core_done = 1'b1; tick(); core_done = 1'b0;
    endtask

    task automatic nmi_pulse();
        nmi_in = 1'b1; tick(); nmi_in = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog got=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;

        // R1: reset state
        offer(0, 0, 0, 1);
        chain(0, 0, 0, 1);
        rd(A_ES, 0, 1);
        rd(A_PS, 0, 1);
        rd(A_ACT, 0, 1);
        rd(A_MODE, 0, 1);
        rd(A_SPLIT, 0, 1);
        rd(A_PRIO0, 0, 1);

        // R2: enable set/clear views
        wr(A_ES, 32'h05);
        rd(A_ES, 32'h05, 2);
        rd(A_EC, 32'h05, 2);
        wr(A_ES, 32'h00);
        rd(A_ES, 32'h05, 2);
        wr(A_EC, 32'h04);
        rd(A_EC, 32'h01, 2);
        wr(A_EC, 32'h00);
        rd(A_ES, 32'h01, 2);
        wr(A_EC, 32'h01);
        rd(A_ES, 32'h00, 2);

        // R3: pending set/clear views, set wins over clear
        wr(A_PS, 32'h0A);
        rd(A_PC, 32'h0A, 3);
        wr(A_PC, 32'h08);
        rd(A_PS, 32'h02, 3);
        wr(A_PC, 32'h02);
        rd(A_PS, 32'h00, 3);
        wr(A_MODE, 32'h08);
        rd(A_MODE, 32'h08, 4);
        wr(A_PS, 32'h08);
        irq_in[3] = 1'b1;
        wr(A_PC, 32'h08);          // pulse edge and clear in the same cycle
        rd(A_PS, 32'h08, 3);
        irq_in[3] = 1'b0;
        wr(A_PC, 32'h08);
        rd(A_PS, 32'h00, 3);

        // R4: level and pulse detection
        irq_in[1] = 1'b1; tick(); irq_in[1] = 1'b0;
        rd(A_PS, 32'h02, 4);
        wr(A_PC, 32'h02);
        rd(A_PS, 32'h00, 4);
        irq_in[1] = 1'b1;
        wr(A_PC, 32'h02);          // level still held: re-pended
        rd(A_PS, 32'h02, 4);
        irq_in[1] = 1'b0;
        tick();
        wr(A_PC, 32'h02);
        rd(A_PS, 32'h00, 4);
        irq_in[3] = 1'b1; tick(); irq_in[3] = 1'b0;
        repeat (3) tick();
        rd(A_PS, 32'h08, 4);       // pulse latched after input fell
        wr(A_PC, 32'h08);
        irq_in[3] = 1'b1; tick();
        wr(A_PC, 32'h08);          // held high, no new edge
        rd(A_PS, 32'h00, 4);
        irq_in[3] = 1'b0;
        tick();

        // R5: software trigger
        wr(A_SW, 32'd6);
        rd(A_PS, 32'h40, 5);
        wr(A_SW, 32'd9);
        rd(A_PS, 32'h40, 5);
        wr(A_SW, 32'd8);
        rd(A_PS, 32'h40, 5);
        rd(A_SW, 32'h0, 5);
        wr(A_PC, 32'hFF);

        // R7: priority field layout
        wr(A_PRIO0, 32'h76543210);
        rd(A_PRIO0, 32'h76543210, 7);

        // R6: selection order
        wr(A_PRIO0, 32'hF13FF3FF); // line2=3, line5=3, line6=1, others 15
        wr(A_ES, 32'hFF);
        wr(A_PS, 32'h24);
        offer(1, 0, 2, 6);         // tie on priority 3: lowest line number
        wr(A_PS, 32'h40);
        offer(1, 0, 6, 6);
        wr(A_PRIO0, 32'hF43FF3FF); // line6 now 4
        offer(1, 0, 2, 7);         // new priority used the next cycle
        wr(A_EC, 32'h04);
        offer(1, 0, 5, 6);         // disabled line skipped
        wr(A_PC, 32'hFF);
        wr(A_ES, 32'hFF);
        offer(0, 0, 0, 6);

        // R8: split and preemption. line1=5, line2=4, line3=8, line4=1
        wr(A_PRIO0, 32'hFFF1845F);
        wr(A_SPLIT, 32'h2);
        rd(A_SPLIT, 32'h2, 8);
        wr(A_PS, 32'h06);
        offer(1, 0, 2, 8);         // same group, subpriority decides
        wr(A_PC, 32'h06);

        // R9: acknowledge
        wr(A_PS, 32'h08);
        offer(1, 0, 3, 9);
        ack();
        rd(A_ACT, 32'h08, 9);
        rd(A_PS, 32'h00, 9);
        offer(0, 0, 0, 9);
        wr(A_PS, 32'h02);
        offer(1, 0, 1, 8);         // group 1 preempts group 2
        ack();
        rd(A_ACT, 32'h0A, 9);
        wr(A_PS, 32'h04);
        offer(0, 0, 0, 8);         // same group as running line1: held
        ack();                     // nothing offered: ignored
        rd(A_ACT, 32'h0A, 9);
        rd(A_PS, 32'h04, 9);

        // R10: tail-chaining
        done();
        chain(1, 0, 2, 10);
        rd(A_ACT, 32'h0C, 10);
        rd(A_PS, 32'h00, 10);
        done();
        chain(0, 0, 0, 10);
        rd(A_ACT, 32'h08, 10);

        // R11: non-maskable request
        wr(A_PS, 32'h10);
        offer(1, 0, 4, 8);
        nmi_pulse();
        offer(1, 1, 0, 11);
        ack();
        offer(0, 0, 0, 11);        // busy: line4 held back
        rd(A_ACT, 32'h08, 11);
        done();
        chain(1, 0, 4, 10);        // chained out of the non-maskable handler
        rd(A_ACT, 32'h18, 10);
        done();
        chain(0, 0, 0, 10);
        rd(A_ACT, 32'h08, 10);
        nmi_pulse();
        offer(1, 1, 0, 11);
        done();
        chain(1, 1, 0, 11);        // chained into the non-maskable handler
        rd(A_ACT, 32'h00, 11);
        offer(0, 0, 0, 11);
        done();
        wr(A_PS, 32'h08);
        offer(1, 0, 3, 11);

        tick();
        wait (sb.size() == 0);
        #1;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule